// File: doc/BRIEF.md
# Host Access Lock Filter

This block sits between a host-side register bus and a group of peripheral modules. Firmware owns one lock bit per module. While a module's lock is clear, host reads and writes to it pass through unchanged. While the lock is set, the filter blocks host traffic to that module. A blocked write is dropped. A blocked read returns zero and never pulses the peripheral's read strobe, so reads with side effects cannot happen. A blocked access still completes in the same cycle as any other access, without stalling and without an error response.

Every blocked attempt sets a sticky violation flag for the module involved. Firmware reads the lock and violation registers through its own small register port. It clears violation flags by writing ones, and a violation arriving in the same cycle wins over the clear. The host has no path to either register. The host module select arrives already decoded, one bit per module.

Top module: `lkf_top`

## Requirements
- R1: After reset every lock bit and every violation flag is 0, and the firmware port reads 0 from both registers.
- R2: A host write to a module whose lock is clear raises that module's bit of `periph_wr` in the same cycle, and `periph_wdata` equals `host_wdata`.
- R3: A host read from a module whose lock is clear raises that module's bit of `periph_rd` in the same cycle, and `host_rdata` returns that module's slice of `periph_rdata`. Module i uses bits [i*DATA_W +: DATA_W].
- R4: A host write to a locked module leaves `periph_wr` all zero.
- R5: A host read from a locked module returns 0 on `host_rdata` and leaves `periph_rd` all zero.
- R6: A host read or write to a locked module sets that module's violation flag at the next clock edge. The flag is visible on `viol_flags` and at firmware register address 1.
- R7: Violation flags are sticky. A firmware write to address 1 clears exactly the flags whose data bits are 1. Flags whose data bits are 0 are unchanged.
- R8: When a clear by firmware and a new violation hit the same flag in the same cycle, the flag ends up set.
- R9: A firmware write to address 0 loads the lock register, with bit i locking module i. The new value takes effect from the next cycle and reads back at address 0. Each module's lock affects only that module.
- R10: Host accesses to modules whose lock is clear never set a violation flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | N_MOD | Decoded module select, at most one bit set |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data; 0 when the selected module is locked |
| periph_rd | output | N_MOD | Gated read strobe for each module |
| periph_wr | output | N_MOD | Gated write strobe for each module |
| periph_wdata | output | DATA_W | Write data forwarded to the modules |
| periph_rdata | input | N_MOD*DATA_W | Read data from each module, packed |
| fw_wr | input | 1 | Firmware register write strobe |
| fw_addr | input | 1 | Firmware register select: 0 lock, 1 violation |
| fw_wdata | input | N_MOD | Firmware write data |
| fw_rdata | output | N_MOD | Firmware read data for the selected register |
| viol_flags | output | N_MOD | Sticky violation flags |

## Verification
A lock bit that is wrong shows up in the same cycle as the next host access to that module. Either a strobe leaks to the peripheral, or data comes back where zero was expected, or zero comes back where data was expected. A violation register that is wrong shows up one edge after the access, or one edge after a firmware clear, on `viol_flags` and at firmware address 1. So every check compares port values at most one cycle after its stimulus.

// File: rtl/lkf_pkg.sv
package lkf_pkg;
  typedef enum logic {
    FW_LOCK = 1'b0,
    FW_VIOL = 1'b1
  } fw_reg_e;
endpackage

// File: rtl/lkf_gate.sv
module lkf_gate #(
  parameter int N_MOD  = 4,
  parameter int DATA_W = 8
) (
  input  logic                    host_rd,
  input  logic                    host_wr,
  input  logic [N_MOD-1:0]        host_sel,
  input  logic [N_MOD-1:0]        lock,
  input  logic [N_MOD*DATA_W-1:0] periph_rdata,
  output logic [N_MOD-1:0]        periph_rd,
  output logic [N_MOD-1:0]        periph_wr,
  output logic [DATA_W-1:0]       host_rdata,
  output logic [N_MOD-1:0]        blocked
);
  logic [N_MOD-1:0] pass;

  function automatic logic [DATA_W-1:0] pick_data(
    input logic [N_MOD-1:0]        en,
    input logic [N_MOD*DATA_W-1:0] flat
  );
    logic [DATA_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < N_MOD; k++)
      if (en[k]) acc = acc | flat[k*DATA_W +: DATA_W];
    return acc;
  endfunction

  for (genvar g = 0; g < N_MOD; g++) begin : g_mod
    assign pass[g]      = host_sel[g] & ~lock[g];
    assign periph_rd[g] = host_rd & pass[g];
    assign periph_wr[g] = host_wr & pass[g];
    assign blocked[g]   = host_sel[g] & lock[g] & (host_rd | host_wr);
  end

  always_comb host_rdata = host_rd ? pick_data(pass, periph_rdata) : '0;
endmodule

// File: rtl/lkf_viol.sv
module lkf_viol #(
  parameter int N_MOD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MOD-1:0] set_mask,
  input  logic [N_MOD-1:0] clr_mask,
  output logic [N_MOD-1:0] viol_q
);
  function automatic logic [N_MOD-1:0] next_flags(
    input logic [N_MOD-1:0] cur,
    input logic [N_MOD-1:0] set,
    input logic [N_MOD-1:0] clr
  );
    return (cur & ~clr) | set;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) viol_q <= '0;
    else        viol_q <= next_flags(viol_q, set_mask, clr_mask);
endmodule

// File: rtl/lkf_fwregs.sv
module lkf_fwregs
  import lkf_pkg::*;
#(
  parameter int N_MOD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fw_wr,
  input  logic             fw_addr,
  input  logic [N_MOD-1:0] fw_wdata,
  input  logic [N_MOD-1:0] viol_q,
  output logic [N_MOD-1:0] lock_q,
  output logic [N_MOD-1:0] viol_clr,
  output logic [N_MOD-1:0] fw_rdata
);
  fw_reg_e sel;
  logic    lock_we;

  assign sel      = fw_reg_e'(fw_addr);
  assign lock_we  = fw_wr && (sel == FW_LOCK);
  assign viol_clr = (fw_wr && (sel == FW_VIOL)) ? fw_wdata : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       lock_q <= '0;
    else if (lock_we) lock_q <= fw_wdata;

  always_comb fw_rdata = (sel == FW_LOCK) ? lock_q : viol_q;
endmodule

// File: rtl/lkf_top.sv
module lkf_top #(
  parameter int N_MOD  = 4,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_rd,
  input  logic                    host_wr,
  input  logic [N_MOD-1:0]        host_sel,
  input  logic [DATA_W-1:0]       host_wdata,
  output logic [DATA_W-1:0]       host_rdata,
  output logic [N_MOD-1:0]        periph_rd,
  output logic [N_MOD-1:0]        periph_wr,
  output logic [DATA_W-1:0]       periph_wdata,
  input  logic [N_MOD*DATA_W-1:0] periph_rdata,
  input  logic                    fw_wr,
  input  logic                    fw_addr,
  input  logic [N_MOD-1:0]        fw_wdata,
  output logic [N_MOD-1:0]        fw_rdata,
  output logic [N_MOD-1:0]        viol_flags
);
  logic [N_MOD-1:0] lock_q;
  logic [N_MOD-1:0] blocked;
  logic [N_MOD-1:0] viol_clr;

  assign periph_wdata = host_wdata;

  lkf_gate #(.N_MOD(N_MOD), .DATA_W(DATA_W)) gate_i (
    .host_rd(host_rd), .host_wr(host_wr), .host_sel(host_sel),
    .lock(lock_q), .periph_rdata(periph_rdata),
    .periph_rd(periph_rd), .periph_wr(periph_wr),
    .host_rdata(host_rdata), .blocked(blocked)
  );

  lkf_fwregs #(.N_MOD(N_MOD)) regs_i (
    .clk(clk), .rst_n(rst_n), .fw_wr(fw_wr), .fw_addr(fw_addr),
    .fw_wdata(fw_wdata), .viol_q(viol_flags), .lock_q(lock_q),
    .viol_clr(viol_clr), .fw_rdata(fw_rdata)
  );

  lkf_viol #(.N_MOD(N_MOD)) viol_i (
    .clk(clk), .rst_n(rst_n), .set_mask(blocked),
    .clr_mask(viol_clr), .viol_q(viol_flags)
  );
endmodule

// File: rtl/lkf_chk.sv
module lkf_chk #(
  parameter int N_MOD  = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_rd,
  input logic              host_wr,
  input logic [N_MOD-1:0]  host_sel,
  input logic [DATA_W-1:0] host_rdata,
  input logic [N_MOD-1:0]  periph_rd,
  input logic [N_MOD-1:0]  periph_wr,
  input logic [N_MOD-1:0]  lock_q,
  input logic [N_MOD-1:0]  blocked,
  input logic [N_MOD-1:0]  viol_clr,
  input logic [N_MOD-1:0]  viol_flags
);
  p_lock_nowr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_wr & lock_q) == '0);

  p_lock_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && $onehot0(host_sel) && (host_sel & lock_q) != '0)
      |-> (host_rdata == '0 && periph_rd == '0));

  p_fwd_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && $onehot0(host_sel) && (host_sel & lock_q) == '0)
      |-> periph_wr == host_sel);

  p_viol_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked != '0) |=> ((viol_flags & $past(blocked)) == $past(blocked)));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(viol_flags) & ~$past(viol_clr) & ~viol_flags) == '0));

  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked == '0) |=> (viol_flags == ($past(viol_flags) & ~$past(viol_clr))));
endmodule

bind lkf_top lkf_chk #(.N_MOD(N_MOD), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
  .host_sel(host_sel), .host_rdata(host_rdata), .periph_rd(periph_rd),
  .periph_wr(periph_wr), .lock_q(lock_q), .blocked(blocked),
  .viol_clr(viol_clr), .viol_flags(viol_flags)
);

// File: tb/lkf_top_tb_top.sv
`timescale 1ns/1ps
module lkf_top_tb_top;
  localparam int N  = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_rd = 1'b0, host_wr = 1'b0;
  logic [N-1:0]  host_sel = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic [N-1:0]  periph_rd, periph_wr;
  logic [DW-1:0] periph_wdata;
  logic [N*DW-1:0] periph_rdata;
  logic          fw_wr = 1'b0, fw_addr = 1'b0;
  logic [N-1:0]  fw_wdata = '0;
  logic [N-1:0]  fw_rdata, viol_flags;

  always #10 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_pd
    assign periph_rdata[g*DW +: DW] = DW'(8'hA0 + g);
  end

  lkf_top #(.N_MOD(N), .DATA_W(DW)) dut_i (.*);

  typedef enum int {K_HRD, K_PRD, K_PWR, K_PWD, K_FWR, K_VIO} kind_e;
  typedef struct { kind_e kind; int exp; string req; } item_t;
  item_t q[$];
  event  sample_ev;
  int    total = 0, bad = 0;
  bit    done = 0;

  always begin
    @(sample_ev);
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      case (it.kind)
        K_HRD: act = int'(host_rdata);
        K_PRD: act = int'(periph_rd);
        K_PWR: act = int'(periph_wr);
        K_PWD: act = int'(periph_wdata);
        K_FWR: act = int'(fw_rdata);
        default: act = int'(viol_flags);
      endcase
      total++;
      if (act != it.exp) begin
        bad++;
        $display("FAIL %s: kind=%0d actual=0x%0h expected=0x%0h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_val(kind_e k, int v, string r);
    item_t it;
    it.kind = k; it.exp = v; it.req = r;
    q.push_back(it);
    ->sample_ev;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    host_rd = 0; host_wr = 0; host_sel = '0; fw_wr = 0;
    #1;
  endtask

  task automatic fw_write(bit a, logic [N-1:0] d);
    @(negedge clk);
    fw_wr = 1; fw_addr = a; fw_wdata = d;
    @(negedge clk);
    fw_wr = 0;
    #1;
  endtask

  task automatic host_op(bit rd, bit wr, logic [N-1:0] sel, logic [DW-1:0] wd);
    @(negedge clk);
    host_rd = rd; host_wr = wr; host_sel = sel; host_wdata = wd;
    #2;
  endtask

  task automatic fw_peek(bit a, int v, string r);
    fw_addr = a; #1;
    expect_val(K_FWR, v, r);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    fw_peek(0, 0, "R1 lock reset");
    fw_peek(1, 0, "R1 viol reset");
    expect_val(K_VIO, 0, "R1 flags reset");

    fw_write(0, 4'b0100);
    fw_peek(0, 4'b0100, "R9 lock readback");

    host_op(0, 1, 4'b0001, 8'h5A);
    expect_val(K_PWR, 4'b0001, "R2 write strobe");
    expect_val(K_PWD, 8'h5A, "R2 write data");
    host_op(1, 0, 4'b0010, 8'h00);
    expect_val(K_PRD, 4'b0010, "R3 read strobe");
    expect_val(K_HRD, 8'hA1, "R3 read data");
    idle();
    expect_val(K_VIO, 0, "R10 no flag from open access");

    host_op(0, 1, 4'b0100, 8'h33);
    expect_val(K_PWR, 0, "R4 locked write dropped");
    idle();
    expect_val(K_VIO, 4'b0100, "R6 flag after locked write");
    fw_peek(1, 4'b0100, "R6 flag at fw addr 1");

    fw_write(1, 4'b0100);
    expect_val(K_VIO, 0, "R7 clear by one");
    host_op(1, 0, 4'b0100, 8'h00);
    expect_val(K_HRD, 0, "R5 locked read zero");
    expect_val(K_PRD, 0, "R5 no read strobe");
    idle();
    expect_val(K_VIO, 4'b0100, "R6 flag after locked read");

    fw_write(1, 4'b1011);
    expect_val(K_VIO, 4'b0100, "R7 zero bits keep flag");
    idle();
    expect_val(K_VIO, 4'b0100, "R7 sticky");

    @(negedge clk);
    host_rd = 1; host_sel = 4'b0100; fw_wr = 1; fw_addr = 1; fw_wdata = 4'b0100;
    idle();
    expect_val(K_VIO, 4'b0100, "R8 set beats clear");

    fw_write(0, 4'b0101);
    host_op(1, 0, 4'b0010, 8'h00);
    expect_val(K_HRD, 8'hA1, "R9 other module still open");
    host_op(1, 0, 4'b0001, 8'h00);
    expect_val(K_HRD, 0, "R9 newly locked module");
    host_op(0, 1, 4'b1000, 8'hC3);
    expect_val(K_PWR, 4'b1000, "R2 write to module 3");
    idle();
    expect_val(K_VIO, 4'b0101, "R6 flag for module 0 only");

    fw_write(0, 4'b0000);
    fw_write(1, 4'b1111);
    host_op(1, 0, 4'b0100, 8'h00);
    expect_val(K_HRD, 8'hA2, "R9 unlock restores access");
    idle();
    expect_val(K_VIO, 0, "R10 open read after unlock");

    idle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule